// File: doc/BRIEF.md
# Conditional Branch Evaluation Unit

This block sits between the control unit and a 16-bit program counter and decides whether a jump request actually reaches the counter. An 8-bit operand is captured from the low byte of the shared data bus into a local holding register. Two flags are derived from the held value. One is a zero flag. The other is a sign flag, which reads the byte as two's complement so that bit 7 set means negative.

A 2-bit condition select from the control unit picks one of four tests: unconditional, zero, non-negative, or negative. The incoming program-counter load request is passed to the output only when the selected test holds. The output is combinational in the request, the select and the held flags, so the counter sees the gated load in the same cycle as the request.

Top module: `branch_gate_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears the held operand to 0x00.
- R2: When opnd_load is high at a rising clock edge, the held operand takes opnd_in. When opnd_load is low, the held operand keeps its value.
- R3: With cond_sel = 2'b00 (unconditional), pc_load equals load_req.
- R4: With cond_sel = 2'b01 (zero test), pc_load is high only when load_req is high and the held operand equals 0x00.
- R5: With cond_sel = 2'b10 (non-negative test), pc_load is high only when load_req is high and bit 7 of the held operand is 0.
- R6: With cond_sel = 2'b11 (negative test), pc_load is high only when load_req is high and bit 7 of the held operand is 1.
- R7: When load_req is low, pc_load is low for every condition and operand.
- R8: pc_load follows load_req and cond_sel within the same cycle. A newly captured operand affects pc_load only from the cycle after its capture edge; the value waiting on opnd_in has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opnd_in | input | 8 | Operand taken from the low data-bus byte |
| opnd_load | input | 1 | Captures opnd_in at the next rising edge |
| cond_sel | input | 2 | Selects the condition: 0 always, 1 zero, 2 non-negative, 3 negative |
| load_req | input | 1 | Program-counter load request from the control unit |
| pc_load | output | 1 | Gated load request to the program counter |

## Verification
The operands used include 0x00, 0x01, 0x7F, 0x80 and 0xFF, tried under every condition code with the request both high and low. The step from 0x7F to 0x80 separates the non-negative test from the negative test. The pair 0x00 and 0x01 separates the zero test from the non-negative test. Directed cycles present a different byte on opnd_in in the capture cycle, or with the load enable low, which shows that only the held value is tested. Seeded random sequences then mix captures, holds, resets and all four codes against a bench model of the held byte.

// File: rtl/br_pkg.sv
package br_pkg;

  typedef enum logic [1:0] {
    COND_ALWAYS = 2'b00,
    COND_ZERO   = 2'b01,
    COND_NONNEG = 2'b10,
    COND_NEG    = 2'b11
  } cond_e;

  // Decide whether the selected test holds for the given flags.
  function automatic logic cond_holds(input cond_e code, input logic zero, input logic neg);
    logic ok;
    case (code)
      COND_ALWAYS: ok = 1'b1;
      COND_ZERO:   ok = zero;
      COND_NONNEG: ok = ~neg;
      COND_NEG:    ok = neg;
      default:     ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/bcu_operand_reg.sv
module bcu_operand_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/bcu_flag_detect.sv
module bcu_flag_detect #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  output logic         is_zero,
  output logic         is_neg
);
  // Ripple OR chain across the bits; the last stage is "any bit set".
  logic [W-1:0] any_set;
  assign any_set[0] = val[0];
  for (genvar i = 1; i < W; i++) begin : g_or
    assign any_set[i] = any_set[i-1] | val[i];
  end
  assign is_zero = ~any_set[W-1];
  assign is_neg  = val[W-1];
endmodule

// File: rtl/bcu_cond_select.sv
module bcu_cond_select
  import br_pkg::*;
(
  input  logic [1:0] cond_sel,
  input  logic       is_zero,
  input  logic       is_neg,
  input  logic       load_req,
  output logic       pc_load
);
  logic cond_ok;
  always_comb begin
    cond_ok = cond_holds(cond_e'(cond_sel), is_zero, is_neg);
    pc_load = load_req & cond_ok;
  end
endmodule

// File: rtl/branch_gate_unit.sv
module branch_gate_unit #(
  parameter int OPND_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPND_W-1:0] opnd_in,
  input  logic              opnd_load,
  input  logic [1:0]        cond_sel,
  input  logic              load_req,
  output logic              pc_load
);
  logic [OPND_W-1:0] held_q;
  logic              is_zero;
  logic              is_neg;

  bcu_operand_reg #(.W(OPND_W)) u_reg (
    .clk(clk), .rst(rst), .en(opnd_load), .d(opnd_in), .q(held_q)
  );

  bcu_flag_detect #(.W(OPND_W)) u_flags (
    .val(held_q), .is_zero(is_zero), .is_neg(is_neg)
  );

  bcu_cond_select u_sel (
    .cond_sel(cond_sel), .is_zero(is_zero), .is_neg(is_neg),
    .load_req(load_req), .pc_load(pc_load)
  );
endmodule

// File: rtl/branch_gate_checks.sv
module branch_gate_checks #(
  parameter int OPND_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [OPND_W-1:0] opnd_in,
  input logic              opnd_load,
  input logic [1:0]        cond_sel,
  input logic              load_req,
  input logic              pc_load,
  input logic [OPND_W-1:0] held,
  input logic              zero_flag
);
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    opnd_load |=> held == $past(opnd_in));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !opnd_load |=> $stable(held));

  p_always_r3: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 2'b00) |-> pc_load == load_req);

  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 2'b01 && load_req) |-> pc_load == (held == '0));

  p_zero_flag_r4: assert property (@(posedge clk) disable iff (rst)
    zero_flag == (held == '0));

  p_nonneg_r5: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 2'b10 && load_req) |-> pc_load == !held[OPND_W-1]);

  p_neg_r6: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 2'b11 && load_req) |-> pc_load == held[OPND_W-1]);

  p_no_req_r7: assert property (@(posedge clk) disable iff (rst)
    !load_req |-> !pc_load);
endmodule

bind branch_gate_unit branch_gate_checks #(.OPND_W(OPND_W)) u_checks (
  .clk(clk), .rst(rst), .opnd_in(opnd_in), .opnd_load(opnd_load),
  .cond_sel(cond_sel), .load_req(load_req), .pc_load(pc_load),
  .held(held_q), .zero_flag(is_zero)
);

// File: tb/branch_gate_unit_test.sv
`timescale 1ns/1ps
module branch_gate_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opnd_in = '0;
  logic       opnd_load = 1'b0;
  logic [1:0] cond_sel = '0;
  logic       load_req = 1'b0;
  logic       pc_load;

  int checks = 0;
  int errors = 0;
  logic [7:0] model_held = '0;

  always #2.5 clk = ~clk;

  branch_gate_unit uut (
    .clk(clk), .rst(rst), .opnd_in(opnd_in), .opnd_load(opnd_load),
    .cond_sel(cond_sel), .load_req(load_req), .pc_load(pc_load)
  );

  // Expected gated output, written as a table of cases on the held byte.
  function automatic logic expect_load(input logic [7:0] h, input logic [1:0] c, input logic r);
    if (!r) return 1'b0;
    if (c == 2'd0) return 1'b1;
    if (c == 2'd1) return (h == 8'd0);
    if (c == 2'd2) return (h < 8'd128);
    return (h >= 8'd128);
  endfunction

  function automatic string tag_for(input logic [1:0] c, input logic r);
    if (!r) return "R7";
    case (c)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // One cycle: drive on the falling edge, check the combinational output,
  // then update the model at the rising edge.
  task automatic step(input logic rs, input logic [7:0] d, input logic ld,
                      input logic [1:0] c, input logic r, input string tag);
    logic exp;
    string t;
    @(negedge clk);
    rst = rs; opnd_in = d; opnd_load = ld; cond_sel = c; load_req = r;
    #1;
    exp = expect_load(model_held, c, r);
    t = (tag == "") ? tag_for(c, r) : tag;
    checks++;
    if (pc_load !== exp) begin
      errors++;
      $display("FAIL %s: pc_load=%b expected %b (held model %h, code %0d, req %b)",
               t, pc_load, exp, model_held, c, r);
    end
    @(posedge clk);
    if (rs) model_held = 8'h00;
    else if (ld) model_held = d;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_held = 8'h5A;
    // R1: an odd byte is captured during reset, yet the held value is cleared.
    step(1'b1, 8'h5A, 1'b1, 2'd1, 1'b0, "R1");
    step(1'b1, 8'h5A, 1'b1, 2'd1, 1'b0, "R1");
    step(1'b0, 8'h00, 1'b0, 2'd1, 1'b1, "R1"); // zero test passes after reset
    step(1'b0, 8'h00, 1'b0, 2'd3, 1'b1, "R1"); // negative test blocks

    // R2 with R8: capture 0x80; the capture cycle still uses the old byte 0x00.
    step(1'b0, 8'h80, 1'b1, 2'd1, 1'b1, "R8");
    step(1'b0, 8'h00, 1'b0, 2'd3, 1'b1, "R2"); // now negative
    step(1'b0, 8'h00, 1'b0, 2'd1, 1'b1, "R2"); // enable low: 0x00 on bus is ignored
    step(1'b0, 8'h00, 1'b0, 2'd3, 1'b1, "R2");

    // R3 to R7 at the sign and zero boundaries.
    foreach (bounds_dummy[k]) ;
    for (int v = 0; v < 5; v++) begin
      logic [7:0] b;
      case (v)
        0: b = 8'h00; 1: b = 8'h01; 2: b = 8'h7F; 3: b = 8'h80; default: b = 8'hFF;
      endcase
      step(1'b0, b, 1'b1, 2'd0, 1'b0, "");
      for (int c = 0; c < 4; c++) begin
        step(1'b0, ~b, 1'b0, 2'(c), 1'b1, "");
        step(1'b0, ~b, 1'b0, 2'(c), 1'b0, "");
      end
    end

    // R8: the request toggles in consecutive cycles and the output follows.
    step(1'b0, 8'h00, 1'b0, 2'd0, 1'b1, "R8");
    step(1'b0, 8'h00, 1'b0, 2'd0, 1'b0, "R8");
    step(1'b0, 8'h00, 1'b0, 2'd0, 1'b1, "R8");

    // Random mix of captures, holds, rare resets and all codes.
    for (int n = 0; n < 400; n++) begin
      logic [7:0] d;
      logic [3:0] pick;
      pick = 4'($urandom_range(0, 15));
      d = (pick < 4) ? 8'h00 : (pick < 6) ? 8'h80 : 8'($urandom);
      step(($urandom_range(0, 49) == 0), d, 1'($urandom), 2'($urandom),
           ($urandom_range(0, 3) != 0), "");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int bounds_dummy[1];
endmodule